// File: doc/BRIEF.md
# Stride Prefetcher Reference Prediction Table

This block watches the stream of executed loads and stores and learns, for each instruction, whether it walks memory with a constant stride. It keeps a direct-mapped table with one entry per set. Each entry holds an owner tag, the last address, the last stride, a 3-bit confidence score, a lookahead count and a miss-history flag. Once an instruction has repeated its stride often enough, each new access can raise a prefetch request for an address some strides ahead of the current one. The lookahead grows by one stride with every request until it reaches its limit.

An entry keeps its owner until its confidence has decayed to zero. Only then can a different instruction claim it. A per-entry miss flag throttles requests: an instruction only prefetches when the current access misses the cache, or when it has missed since its last stride break. This stops unrolled loops, where every instruction crosses a full line, from flooding the memory pipeline with duplicate requests.

The trace input has no ready signal and is accepted in every cycle it is valid. The request output is a valid/ready stream with fire-and-forget rules. `pf_valid` is high for exactly the one cycle after the triggering access. If `pf_ready` is low in that cycle, the request is lost and is never offered again. The output never stalls the learning logic.

Top module: `rpt_prefetcher`

## Requirements
- R1: After reset `pf_valid` is low and every table entry is empty, so the first access of any instruction raises no request.
- R2: The set index is PC bits [8:2] (128 sets). The tag is PC bits [31:9] together with PC bits [1:0]. An access owns an entry only when the entry is filled and its tag equals the access tag.
- R3: On an owned access, the stride is the current address minus the stored address, taken modulo 2^32. The stored address always becomes the current address. The 3-bit score rises by one, saturating at 7, when the stride equals the stored stride. Otherwise it falls by one, saturating at 0, and the new stride is stored.
- R4: An owned access raises a request only when all of the following hold: its stride equals the stored stride, the updated score is 2 or more, and either the access misses or the entry's miss flag is already set.
- R5: The request address is the current address plus the stride times (lookahead + 1). The lookahead grows by one with each request and stops at 4. A stride break clears it.
- R6: A miss sets the entry's miss flag. A stride break without a miss clears it. When a miss and a stride break happen together, the flag is set.
- R7: An access with a different tag claims the entry only when the entry's score is 0 or the entry is empty. Claiming stores the tag and address, and sets stride 0, score 0, lookahead 0 and miss flag equal to the access's miss. Otherwise the foreign access only lowers the owner's score by one.
- R8: `pf_valid` rises in the cycle after the triggering access and lasts one cycle. A request not taken in that cycle is dropped, yet it still counts toward the lookahead.
- R9: With `pf_enable` low, no request is raised. Learning continues, and the lookahead does not grow.
- R10: An owned access whose stride is zero never raises a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pf_enable | input | 1 | High allows prefetch requests |
| trc_valid | input | 1 | An executed load/store is presented |
| trc_pc | input | 32 | Program counter of that instruction |
| trc_addr | input | 32 | Virtual address it accessed |
| trc_miss | input | 1 | The access missed the cache |
| pf_valid | output | 1 | Prefetch request present, for one cycle |
| pf_ready | input | 1 | Consumer takes the request this cycle |
| pf_addr | output | 32 | Address to prefetch |

## Verification
Two things can land on the same entry update: a stride break and a cache miss. They pull the miss flag in opposite directions. The bench forces this by jumping an address to a new region on an access that also misses. It then repeats the new stride with hits only, and a request must appear, which proves the flag stayed set and the lookahead restarted at one stride. A second collision pairs a dropped request, made by holding `pf_ready` low, with the lookahead increment. The next request must land one stride further ahead.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
  localparam int SCORE_W = 3;
  typedef logic [SCORE_W-1:0] score_t;
  localparam score_t SCORE_TOP = '1;

  function automatic score_t score_up(input score_t s);
    return (s == SCORE_TOP) ? s : s + score_t'(1);
  endfunction

  function automatic score_t score_down(input score_t s);
    return (s == '0) ? s : s - score_t'(1);
  endfunction
endpackage

// File: rtl/rpt_table.sv
module rpt_table
  import rpt_pkg::*;
#(
  parameter int SETS   = 128,
  parameter int TAG_W  = 25,
  parameter int ADDR_W = 32,
  parameter int ADV_W  = 3,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  output logic              rd_vld,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] rd_stride,
  output score_t            rd_score,
  output logic [ADV_W-1:0]  rd_adv,
  output logic              rd_missed,
  input  logic              we,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] wr_stride,
  input  score_t            wr_score,
  input  logic [ADV_W-1:0]  wr_adv,
  input  logic              wr_missed
);
  logic              vld_q    [SETS];
  logic [TAG_W-1:0]  tag_q    [SETS];
  logic [ADDR_W-1:0] addr_q   [SETS];
  logic [ADDR_W-1:0] stride_q [SETS];
  score_t            score_q  [SETS];
  logic [ADV_W-1:0]  adv_q    [SETS];
  logic              missed_q [SETS];

  assign rd_vld    = vld_q[idx];
  assign rd_tag    = tag_q[idx];
  assign rd_addr   = addr_q[idx];
  assign rd_stride = stride_q[idx];
  assign rd_score  = score_q[idx];
  assign rd_adv    = adv_q[idx];
  assign rd_missed = missed_q[idx];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[s]    <= 1'b0;
        tag_q[s]    <= '0;
        addr_q[s]   <= '0;
        stride_q[s] <= '0;
        score_q[s]  <= '0;
        adv_q[s]    <= '0;
        missed_q[s] <= 1'b0;
      end else if (we && idx == IDX_W'(s)) begin
        vld_q[s]    <= 1'b1;
        tag_q[s]    <= wr_tag;
        addr_q[s]   <= wr_addr;
        stride_q[s] <= wr_stride;
        score_q[s]  <= wr_score;
        adv_q[s]    <= wr_adv;
        missed_q[s] <= wr_missed;
      end
    end
  end
endmodule

// File: rtl/rpt_update.sv
module rpt_update
  import rpt_pkg::*;
#(
  parameter int     TAG_W     = 25,
  parameter int     ADDR_W    = 32,
  parameter int     ADV_W     = 3,
  parameter int     ADV_MAX   = 4,
  parameter score_t PF_MIN    = 3'd2,
  parameter score_t TAKE_MAX  = 3'd0
) (
  input  logic              acc_valid,
  input  logic [TAG_W-1:0]  acc_tag,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_miss,
  input  logic              enable,
  input  logic              e_vld,
  input  logic [TAG_W-1:0]  e_tag,
  input  logic [ADDR_W-1:0] e_addr,
  input  logic [ADDR_W-1:0] e_stride,
  input  score_t            e_score,
  input  logic [ADV_W-1:0]  e_adv,
  input  logic              e_missed,
  output logic              we,
  output logic [TAG_W-1:0]  w_tag,
  output logic [ADDR_W-1:0] w_addr,
  output logic [ADDR_W-1:0] w_stride,
  output score_t            w_score,
  output logic [ADV_W-1:0]  w_adv,
  output logic              w_missed,
  output logic              issue,
  output logic [ADDR_W-1:0] target
);
  logic              owned, claim, same;
  logic [ADDR_W-1:0] delta, reach;
  score_t            score_nx;

  assign owned    = e_vld && (e_tag == acc_tag);
  assign claim    = !e_vld || (e_score <= TAKE_MAX);
  assign delta    = acc_addr - e_addr;
  assign same     = (delta == e_stride);
  assign score_nx = same ? score_up(e_score) : score_down(e_score);
  assign reach    = delta * (ADDR_W'(e_adv) + ADDR_W'(1));
  assign target   = acc_addr + reach;

  always_comb begin
    we       = 1'b0;
    issue    = 1'b0;
    w_tag    = e_tag;
    w_addr   = e_addr;
    w_stride = e_stride;
    w_score  = e_score;
    w_adv    = e_adv;
    w_missed = e_missed;
    if (acc_valid) begin
      we = 1'b1;
      if (owned) begin
        issue    = enable && same && (delta != '0) && (score_nx >= PF_MIN)
                   && (acc_miss || e_missed);
        w_addr   = acc_addr;
        w_stride = delta;
        w_score  = score_nx;
        w_missed = acc_miss || (same && e_missed);
        if (!same)
          w_adv = '0;
        else if (issue && e_adv < ADV_W'(ADV_MAX))
          w_adv = e_adv + ADV_W'(1);
      end else if (claim) begin
        w_tag    = acc_tag;
        w_addr   = acc_addr;
        w_stride = '0;
        w_score  = '0;
        w_adv    = '0;
        w_missed = acc_miss;
      end else begin
        w_score = score_down(e_score);
      end
    end
  end
endmodule

// File: rtl/rpt_issue.sv
module rpt_issue #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              issue,
  input  logic [ADDR_W-1:0] target,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr
);
  logic req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      pf_addr <= '0;
    end else begin
      req_q <= issue;
      if (issue) pf_addr <= target;
    end
  end

  assign pf_valid = req_q && enable;
endmodule

// File: rtl/rpt_prefetcher.sv
module rpt_prefetcher
  import rpt_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ADDR_W  = 32,
  parameter int SETS    = 128,
  parameter int IDX_LSB = 2,
  parameter int ADV_MAX = 4,
  localparam int IDX_W  = $clog2(SETS),
  localparam int TAG_W  = PC_W - IDX_W,
  localparam int ADV_W  = $clog2(ADV_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pf_enable,
  input  logic              trc_valid,
  input  logic [PC_W-1:0]   trc_pc,
  input  logic [ADDR_W-1:0] trc_addr,
  input  logic              trc_miss,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr
);
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              e_vld, e_missed, we, w_missed, issue;
  logic [TAG_W-1:0]  e_tag, w_tag;
  logic [ADDR_W-1:0] e_addr, e_stride, w_addr, w_stride, target;
  score_t            e_score, w_score;
  logic [ADV_W-1:0]  e_adv, w_adv;
  logic              ready_unused;

  assign idx = trc_pc[IDX_LSB +: IDX_W];
  assign tag = {trc_pc[PC_W-1:IDX_LSB+IDX_W], trc_pc[IDX_LSB-1:0]};
  // Requests are fire-and-forget: acceptance does not alter any state.
  assign ready_unused = pf_ready;

  rpt_table #(.SETS(SETS), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .ADV_W(ADV_W)) u_table (
    .clk(clk), .rst_n(rst_n), .idx(idx),
    .rd_vld(e_vld), .rd_tag(e_tag), .rd_addr(e_addr), .rd_stride(e_stride),
    .rd_score(e_score), .rd_adv(e_adv), .rd_missed(e_missed),
    .we(we), .wr_tag(w_tag), .wr_addr(w_addr), .wr_stride(w_stride),
    .wr_score(w_score), .wr_adv(w_adv), .wr_missed(w_missed)
  );

  rpt_update #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .ADV_W(ADV_W), .ADV_MAX(ADV_MAX)) u_update (
    .acc_valid(trc_valid), .acc_tag(tag), .acc_addr(trc_addr), .acc_miss(trc_miss),
    .enable(pf_enable),
    .e_vld(e_vld), .e_tag(e_tag), .e_addr(e_addr), .e_stride(e_stride),
    .e_score(e_score), .e_adv(e_adv), .e_missed(e_missed),
    .we(we), .w_tag(w_tag), .w_addr(w_addr), .w_stride(w_stride),
    .w_score(w_score), .w_adv(w_adv), .w_missed(w_missed),
    .issue(issue), .target(target)
  );

  rpt_issue #(.ADDR_W(ADDR_W)) u_issue (
    .clk(clk), .rst_n(rst_n), .enable(pf_enable), .issue(issue), .target(target),
    .pf_valid(pf_valid), .pf_addr(pf_addr)
  );
endmodule

// File: rtl/rpt_prefetcher_chk.sv
module rpt_prefetcher_chk #(
  parameter int PC_W   = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pf_enable,
  input logic              trc_valid,
  input logic [PC_W-1:0]   trc_pc,
  input logic [ADDR_W-1:0] trc_addr,
  input logic              trc_miss,
  input logic              pf_valid,
  input logic              pf_ready,
  input logic [ADDR_W-1:0] pf_addr
);
  p_follows_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> $past(trc_valid));

  p_no_replay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !trc_valid |=> !pf_valid);

  p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pf_enable |-> !pf_valid);

  p_ahead_of_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> pf_addr != $past(trc_addr));
endmodule

bind rpt_prefetcher rpt_prefetcher_chk #(.PC_W(PC_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_rpt_prefetcher.sv
`timescale 1ns/1ps
module tb_rpt_prefetcher;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pf_enable = 1'b1;
  logic        trc_valid = 1'b0;
  logic [31:0] trc_pc = '0;
  logic [31:0] trc_addr = '0;
  logic        trc_miss = 1'b0;
  logic        pf_valid;
  logic        pf_ready = 1'b1;
  logic [31:0] pf_addr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rpt_prefetcher dut (
    .clk(clk), .rst_n(rst_n), .pf_enable(pf_enable), .trc_valid(trc_valid),
    .trc_pc(trc_pc), .trc_addr(trc_addr), .trc_miss(trc_miss),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
  );

  localparam logic [31:0] PC_A = 32'h0000_1004;
  localparam logic [31:0] PC_B = 32'h0000_2008;
  localparam logic [31:0] PC_C = 32'h0000_1204;
  localparam logic [31:0] PC_D = 32'h0000_300C;
  localparam logic [31:0] PC_E = 32'h0000_4010;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One access; drive at negedge, sample 1ns after the capturing edge.
  task automatic access(input logic [31:0] pc, input logic [31:0] a, input logic miss,
                        input logic exp_v, input logic [31:0] exp_a, input string req);
    @(negedge clk);
    trc_valid = 1'b1; trc_pc = pc; trc_addr = a; trc_miss = miss;
    @(posedge clk); #1;
    check(req, {31'd0, pf_valid}, {31'd0, exp_v});
    if (exp_v) check(req, pf_addr, exp_a);
    @(negedge clk);
    trc_valid = 1'b0; trc_miss = 1'b0;
  endtask

  task automatic idle_check(input string req);
    @(posedge clk); #1;
    check(req, {31'd0, pf_valid}, 32'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 reset valid", {31'd0, pf_valid}, 32'd0);
    access(PC_A, 32'h1000, 1'b1, 1'b0, 32'h0, "R1 first access");
  endtask

  task automatic t_learn;
    access(PC_A, 32'h1040, 1'b1, 1'b0, 32'h0, "R3 stride break");
    access(PC_A, 32'h1080, 1'b1, 1'b0, 32'h0, "R3 score one");
    access(PC_A, 32'h10C0, 1'b1, 1'b1, 32'h1100, "R4 first request");
    access(PC_A, 32'h1100, 1'b1, 1'b1, 32'h1180, "R5 two ahead");
    access(PC_A, 32'h1140, 1'b1, 1'b1, 32'h1200, "R5 three ahead");
    access(PC_A, 32'h1180, 1'b1, 1'b1, 32'h1280, "R5 four ahead");
    access(PC_A, 32'h11C0, 1'b1, 1'b1, 32'h1300, "R5 five ahead");
    access(PC_A, 32'h1200, 1'b1, 1'b1, 32'h1340, "R5 lookahead capped");
  endtask

  task automatic t_missed;
    access(PC_B, 32'h5000, 1'b0, 1'b0, 32'h0, "R2 separate set");
    access(PC_B, 32'h5010, 1'b0, 1'b0, 32'h0, "R3 learn B");
    access(PC_B, 32'h5020, 1'b0, 1'b0, 32'h0, "R3 learn B");
    access(PC_B, 32'h5030, 1'b0, 1'b0, 32'h0, "R4 no miss no request");
    access(PC_B, 32'h5040, 1'b1, 1'b1, 32'h5050, "R4 miss triggers");
    access(PC_B, 32'h5050, 1'b0, 1'b1, 32'h5070, "R6 flag carries");
    access(PC_B, 32'h6000, 1'b1, 1'b0, 32'h0, "R6 break with miss");
    access(PC_B, 32'h6FB0, 1'b0, 1'b1, 32'h7F60, "R6 set wins R5 cleared");
    access(PC_B, 32'h9000, 1'b0, 1'b0, 32'h0, "R6 break no miss");
    access(PC_B, 32'hB050, 1'b0, 1'b0, 32'h0, "R6 flag cleared");
  endtask

  task automatic t_takeover;
    for (int i = 0; i < 6; i++)
      access(PC_C, 32'h8000, 1'b0, 1'b0, 32'h0, "R7 foreign decays");
    access(PC_A, 32'h1240, 1'b1, 1'b1, 32'h1380, "R7 owner kept R2");
    access(PC_C, 32'h8000, 1'b0, 1'b0, 32'h0, "R7 foreign decays");
    access(PC_C, 32'h8000, 1'b0, 1'b0, 32'h0, "R7 foreign decays");
    access(PC_C, 32'h8000, 1'b1, 1'b0, 32'h0, "R7 claim");
    access(PC_C, 32'h8100, 1'b1, 1'b0, 32'h0, "R7 new owner learns");
    access(PC_C, 32'h8200, 1'b1, 1'b0, 32'h0, "R7 new owner learns");
    access(PC_C, 32'h8300, 1'b1, 1'b1, 32'h8400, "R7 lookahead reset");
    access(PC_A, 32'h1280, 1'b1, 1'b0, 32'h0, "R7 old owner foreign");
  endtask

  task automatic t_disable_and_drop;
    pf_enable = 1'b0;
    access(PC_D, 32'h100, 1'b1, 1'b0, 32'h0, "R9 off");
    access(PC_D, 32'h110, 1'b1, 1'b0, 32'h0, "R9 off");
    access(PC_D, 32'h120, 1'b1, 1'b0, 32'h0, "R9 off");
    access(PC_D, 32'h130, 1'b1, 1'b0, 32'h0, "R9 off eligible");
    pf_enable = 1'b1;
    access(PC_D, 32'h140, 1'b1, 1'b1, 32'h150, "R9 learned lookahead kept");
    pf_ready = 1'b0;
    access(PC_D, 32'h150, 1'b1, 1'b1, 32'h170, "R8 offered while stalled");
    idle_check("R8 dropped not replayed");
    pf_ready = 1'b1;
    access(PC_D, 32'h160, 1'b1, 1'b1, 32'h190, "R8 drop counted");
  endtask

  task automatic t_zero_stride;
    for (int i = 0; i < 5; i++)
      access(PC_E, 32'h700, 1'b1, 1'b0, 32'h0, "R10 zero stride");
  endtask

  initial begin : watchdog
    #400000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_learn();
    t_missed();
    t_takeover();
    t_disable_and_drop();
    t_zero_stride();
    repeat (2) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule